// File: doc/BRIEF.md
# Spindle Phase Detector with Masked Lock

This block closes the digital half of a spindle speed loop. It compares a reference clock with the tachometer pulse taken from one Hall phase. A falling reference edge is matched against a rising tachometer edge. Whichever edge comes first opens an error interval, and the other edge closes it. While the reference leads, the block asks for acceleration. While the tachometer leads, it asks for reverse-torque braking. A companion error pulse is active low. Its duty therefore falls as the demand for drive rises. An external amplifier and loop filter turn that pulse into a current command.

Each error interval is timed in system clock cycles. An interval that closes within a programmable window counts as in phase. A window overrun, or a second edge of the same kind while one is already pending, counts as out of phase. The lock output does not follow the raw in-phase condition. It waits until that condition has lasted for a fixed number of slow timebase ticks, so that brief slips during pull-in are masked. It drops at once when the loop slips. A half-gain flag follows lock, so the drive stage can reduce its loop gain while the motor is locked. Pulling run enable low idles the whole detector.

Top module: `spindle_phase_det`

## Requirements
- R1: Both the reference and tachometer inputs pass through two synchronizing flip-flops. An input change made between clock edges reaches the outputs at the third rising clock edge after the change.
- R2: A reference falling edge with no tachometer edge pending raises `accel_req` and drives `speed_err_n` low (0 = drive demand). Both stay that way until a tachometer rising edge is detected.
- R3: A tachometer rising edge with no reference edge pending raises `decel_req` until a reference falling edge is detected.
- R4: A reference falling edge and a tachometer rising edge detected in the same cycle while nothing is pending produce no accel or decel pulse.
- R5: `accel_req` and `decel_req` are never high together.
- R6: A pending interval that closes after at most WIN_CYC cycles is in phase. It is out of phase if it stays open with WIN_CYC cycles counted and no closing edge arrives. It is also out of phase if an edge of the same kind as the one pending arrives before the closing edge.
- R7: `locked` rises only on a cycle where `slow_tick` is high. It rises on the MASK_TICKS-th tick that is counted after the first in-phase interval that follows reset, run disable or an out-of-phase event. A tick is counted only from the cycle after that interval is seen.
- R8: An out-of-phase event clears `locked` and restarts the mask count at the next clock edge.
- R9: `gain_half` is high exactly when `locked` is high.
- R10: While `run_en` is low, edges are ignored. `accel_req`, `decel_req` and `locked` stay low, `speed_err_n` stays high, and the mask count is held at zero.
- R11: After reset, `speed_err_n` is 1 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_in | input | 1 | Reference clock, asynchronous; falling edges are used |
| tach_in | input | 1 | Tachometer signal from one Hall phase, asynchronous; rising edges are used |
| slow_tick | input | 1 | One-cycle pulse from the slow timebase that paces the lock mask |
| run_en | input | 1 | High to run the detector; low idles it |
| speed_err_n | output | 1 | Active-low phase error pulse |
| accel_req | output | 1 | Reference leads: accelerate |
| decel_req | output | 1 | Tachometer leads: brake |
| gain_half | output | 1 | Select reduced loop gain |
| locked | output | 1 | Masked lock indication |

## Verification
The bound checker watches several properties on every cycle. It confirms that accel and decel never overlap. It confirms that a lone detected edge opens the matching request on the next edge, and that coincident edges open nothing. It also confirms that lock rises only on a tick, falls right after an out-of-phase event, and stays low while the detector is disabled. Other behaviour can only be shown by the bench's stimulus scenarios. These include the three-edge input latency and the exact window boundary. They also include the count of ticks before lock, and behaviour under missing tachometer pulses, doubled tachometer frequency and random phase offsets. The bench checks these against its own cycle model.

// File: rtl/spindle_phase_det.sv
`timescale 1ns/1ps
module spindle_phase_det #(
  parameter int WIN_CYC    = 16,
  parameter int MASK_TICKS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk_in,
  input  logic tach_in,
  input  logic slow_tick,
  input  logic run_en,
  output logic speed_err_n,
  output logic accel_req,
  output logic decel_req,
  output logic gain_half,
  output logic locked
);

  localparam int CNT_W = $clog2(WIN_CYC + 2);
  localparam int MSK_W = $clog2(MASK_TICKS + 1);
  localparam logic [CNT_W-1:0] WIN_V   = CNT_W'(WIN_CYC);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WIN_CYC + 1);
  localparam logic [MSK_W-1:0] MSK_TOP = MSK_W'(MASK_TICKS);
  localparam logic [MSK_W-1:0] MSK_PRE = MSK_W'(MASK_TICKS - 1);

  logic [2:0]       ref_sh, tach_sh;
  logic             up_q, dn_q, in_win;
  logic [CNT_W-1:0] cnt;
  logic [MSK_W-1:0] mask_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sh  <= '0;
      tach_sh <= '0;
    end else begin
      ref_sh  <= {ref_sh[1:0], ref_clk_in};
      tach_sh <= {tach_sh[1:0], tach_in};
    end
  end

  wire ref_fall  = ref_sh[2] & ~ref_sh[1];
  wire tach_rise = ~tach_sh[2] & tach_sh[1];

  wire pend      = up_q | dn_q;
  wire up_a      = up_q | ref_fall;
  wire dn_a      = dn_q | tach_rise;
  wire closing   = up_a & dn_a;
  wire slip      = (up_q & ref_fall) | (dn_q & tach_rise);
  wire overrun   = pend & ~closing & (cnt >= WIN_V);
  wire good_evt  = closing & ~slip & (cnt <= WIN_V);
  wire bad_evt   = slip | overrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
      cnt  <= '0;
    end else if (!run_en) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
      cnt  <= '0;
    end else begin
      up_q <= up_a & ~closing;
      dn_q <= dn_a & ~closing;
      if (closing || !(up_a || dn_a))
        cnt <= '0;
      else if (!pend)
        cnt <= CNT_W'(1);
      else if (cnt != CNT_TOP)
        cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_win   <= 1'b0;
      mask_cnt <= '0;
      locked   <= 1'b0;
    end else if (!run_en || bad_evt) begin
      in_win   <= 1'b0;
      mask_cnt <= '0;
      locked   <= 1'b0;
    end else begin
      if (in_win && slow_tick && mask_cnt != MSK_TOP) begin
        mask_cnt <= mask_cnt + 1'b1;
        if (mask_cnt == MSK_PRE) locked <= 1'b1;
      end
      if (good_evt) in_win <= 1'b1;
    end
  end

  assign accel_req   = up_q;
  assign decel_req   = dn_q;
  assign speed_err_n = ~up_q;
  assign gain_half   = locked;

endmodule

// File: rtl/spindle_phase_det_chk.sv
`timescale 1ns/1ps
module spindle_phase_det_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic slow_tick,
  input logic ref_fall,
  input logic tach_rise,
  input logic pend_up,
  input logic pend_dn,
  input logic bad,
  input logic accel_req,
  input logic decel_req,
  input logic locked
);

  assert_accel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && ref_fall && !tach_rise && !pend_dn) |=> accel_req);

  assert_decel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && tach_rise && !ref_fall && !pend_up) |=> decel_req);

  assert_coincide_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && ref_fall && tach_rise && !pend_up && !pend_dn) |=> (!accel_req && !decel_req));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(accel_req && decel_req));

  assert_lock_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(slow_tick));

  assert_drop_on_slip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && bad) |=> !locked);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!accel_req && !decel_req && !locked));

endmodule

bind spindle_phase_det spindle_phase_det_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .slow_tick (slow_tick),
  .ref_fall  (ref_fall),
  .tach_rise (tach_rise),
  .pend_up   (up_q),
  .pend_dn   (dn_q),
  .bad       (bad_evt),
  .accel_req (accel_req),
  .decel_req (decel_req),
  .locked    (locked)
);

// File: tb/tb_spindle_phase_det.sv
`timescale 1ns/1ps
module tb_spindle_phase_det;

  localparam int WIN  = 16;
  localparam int MASK = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_i = 1'b1, tach_i = 1'b0, tick = 1'b0, run = 1'b1;
  logic err_n, acc, dec, ghalf, lck;

  int vecs = 0, miss = 0;
  bit cmp_on = 1'b0, finished = 1'b0;

  always #10 clk = ~clk;

  spindle_phase_det #(.WIN_CYC(WIN), .MASK_TICKS(MASK)) dut (
    .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_i), .tach_in(tach_i),
    .slow_tick(tick), .run_en(run), .speed_err_n(err_n), .accel_req(acc),
    .decel_req(dec), .gain_half(ghalf), .locked(lck)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Independent cycle model built from the requirements
  bit [2:0] hr, hf;
  int side, len, msk;
  bit inw, lk;

  always @(posedge clk or negedge rst_n) begin
    bit rf, fr, good, bad;
    if (!rst_n) begin
      hr = '0; hf = '0; side = 0; len = 0; msk = 0; inw = 0; lk = 0;
    end else begin
      rf = hr[2] & ~hr[1];
      fr = ~hf[2] & hf[1];
      hr = {hr[1:0], ref_i};
      hf = {hf[1:0], tach_i};
      good = 0; bad = 0;
      if (!run) begin
        side = 0; len = 0; msk = 0; inw = 0; lk = 0;
      end else begin
        if (side == 0) begin
          if (rf && fr) good = 1;
          else if (rf) begin side = 1; len = 1; end
          else if (fr) begin side = 2; len = 1; end
        end else begin
          if ((side == 1 && rf) || (side == 2 && fr)) bad = 1;
          if ((side == 1 && fr) || (side == 2 && rf)) begin
            if (!bad && len <= WIN) good = 1;
            side = 0; len = 0;
          end else begin
            if (len >= WIN) bad = 1;
            if (len <= WIN) len++;
          end
        end
        if (bad) begin
          inw = 0; msk = 0; lk = 0;
        end else begin
          if (inw && tick && msk < MASK) begin
            if (msk == MASK - 1) lk = 1;
            msk++;
          end
          if (good) inw = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R2", "accel_req", acc, side == 1);
      chk("R2", "speed_err_n", err_n, side != 1);
      chk("R3", "decel_req", dec, side == 2);
      chk("R7", "locked", lck, lk);
      chk("R9", "gain_half", ghalf, lk);
    end
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic seg(int mode, int ncyc, int per, int off);
    for (int c = 0; c < ncyc; c++) begin
      int ph, pi, rp, fph;
      @(negedge clk);
      ph  = c % per;
      pi  = c / per;
      rp  = (per / 2 + off + 2 * per) % per;
      fph = (ph - rp + 2 * per) % per;
      ref_i  = (ph < per / 2);
      tach_i = (fph < per / 2);
      if (mode == 2 && (pi % 4) == 3) tach_i = 1'b0;
      if (mode == 3) tach_i = (((ph * 2) % per) < per / 2);
      tick = (c % 5 == 0);
      run  = (mode == 4) ? ($urandom_range(0, 29) != 0) : 1'b1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ref_i = 1'b1; tach_i = 1'b0; tick = 1'b0; run = 1'b1;
    cycles(3);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  endtask

  initial begin
    #(64'd4_000_000);
    miss++;
    $display("FAIL watchdog R1: run did not complete, got hung expected done");
    summary();
  end

  initial begin
    void'($urandom(32'd2718));
    do_reset();
    cmp_on = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "speed_err_n", err_n, 1'b1);
    chk("R11", "accel_req", acc, 1'b0);
    chk("R11", "decel_req", dec, 1'b0);
    chk("R11", "gain_half", ghalf, 1'b0);
    chk("R11", "locked", lck, 1'b0);

    // Constrained random segments: small offsets, large offsets, missing
    // tachometer pulses, doubled tachometer rate, random run drops
    for (int s = 0; s < 15; s++) begin
      int per, off, mode;
      mode = s % 5;
      per  = $urandom_range(24, 60);
      off  = (mode == 1) ? (per / 2 - 2) : ($urandom_range(0, 16) - 8);
      seg(mode, 600, per, off);
    end

    // R1 latency and R2 accel/error pulse
    do_reset();
    cycles(5);
    ref_i = 1'b0;
    @(negedge clk); chk("R1", "accel after 1 edge", acc, 1'b0);
    @(negedge clk); chk("R1", "accel after 2 edges", acc, 1'b0);
    @(negedge clk); chk("R1", "accel after 3 edges", acc, 1'b1);
    chk("R2", "speed_err_n low", err_n, 1'b0);
    tach_i = 1'b1;
    cycles(3);
    chk("R2", "accel cleared by tach rise", acc, 1'b0);
    chk("R2", "speed_err_n back high", err_n, 1'b1);

    // R3 decel
    tach_i = 1'b0; cycles(4);
    ref_i = 1'b1; cycles(4);
    chk("R3", "rising ref ignored", acc | dec, 1'b0);
    tach_i = 1'b1; cycles(3);
    chk("R3", "decel set", dec, 1'b1);
    chk("R5", "no accel with decel", acc, 1'b0);
    ref_i = 1'b0; cycles(3);
    chk("R3", "decel cleared", dec, 1'b0);

    // R4 coincident edges
    ref_i = 1'b1; tach_i = 1'b0; cycles(4);
    ref_i = 1'b0; tach_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R4", "no accel", acc, 1'b0);
      chk("R4", "no decel", dec, 1'b0);
    end

    // R10 run disabled
    run = 1'b0;
    ref_i = 1'b1; cycles(4);
    ref_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R10", "accel idle", acc, 1'b0);
      chk("R10", "speed_err_n idle", err_n, 1'b1);
      chk("R10", "locked idle", lck, 1'b0);
    end
    run = 1'b1; cycles(4);

    // R7 mask tick count, R9 gain
    do_reset();
    cycles(4);
    ref_i = 1'b0; tach_i = 1'b1; cycles(4);
    ref_i = 1'b1; tach_i = 1'b0; cycles(4);
    for (int k = 0; k < MASK - 1; k++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
    chk("R7", "still masked", lck, 1'b0);
    chk("R9", "gain follows", ghalf, 1'b0);
    tick = 1'b1; @(negedge clk);
    tick = 1'b0;
    chk("R7", "lock on last tick", lck, 1'b1);
    chk("R9", "half gain when locked", ghalf, 1'b1);

    // R6 window overrun, R8 immediate loss
    ref_i = 1'b0;
    cycles(WIN + 2);
    chk("R6", "lock held inside window", lck, 1'b1);
    @(negedge clk);
    chk("R8", "lock lost on overrun", lck, 1'b0);
    chk("R9", "gain restored", ghalf, 1'b0);
    tach_i = 1'b1; cycles(5);

    summary();
  end

endmodule